// File: doc/BRIEF.md
# Prefix Mode and Register-Pointer Sequencer

This block keeps the small piece of decode state that prefix opcodes leave for the next instruction of a 16-bit coprocessor with sixteen general registers. That state is made of two alternate-mode bits, a flag that records a pending register-select prefix, and two 4-bit register pointers. One pointer names the source operand and the other names the destination. The decoder presents one opcode byte per cycle together with a valid strobe. The block answers with the current variant mode, the two pointer values and, for the two register-move forms, a one-cycle register-file write command.

The mode state is held in a named state machine with eight states. The state name gives the 2-bit mode and whether a select prefix is pending:

| State | Mode | Select pending |
|-------|------|----------------|
| PS_M0 | 0 | no |
| PS_M0S | 0 | yes |
| PS_M1 | 1 | no |
| PS_M1S | 1 | yes |
| PS_M2 | 2 | no |
| PS_M2S | 2 | yes |
| PS_M3 | 3 | no |
| PS_M3S | 3 | yes |

The transitions are:
- SELECT: a select prefix moves to the select-pending state of the same mode.
- ALTERNATE: an alternate prefix moves to the non-pending state whose mode is the old mode ORed with the prefix bits.
- POINT: a pointer opcode with nothing pending keeps the current state.
- MOVE: a pointer opcode with a select pending goes to PS_M0.
- RETIRE: any other opcode goes to PS_M0.
- HOLD: a cycle with no strobe keeps the current state.

Every ordinary instruction returns the state machine and both pointers to their defaults. The datapath therefore only ever sees prefix effects on the single instruction that follows them.

Top module: `prefix_seq`

## Requirements
- R1: While rst is high at a clock edge, the outputs after that edge are all zero: mode 0, sel_pending 0, src_idx 0, dst_idx 0, wr_en 0 and flag_we 0.
- R2: A strobed opcode 0x2N loads both src_idx and dst_idx with N and sets sel_pending. The mode is left unchanged. Outputs change on the clock edge of the strobe.
- R3: Strobed opcodes 0x3D, 0x3E and 0x3F OR the values 1, 2 and 3 (the opcode's low two bits) into mode = {alt2, alt1}. Each of them clears sel_pending and leaves both pointers unchanged.
- R4: A strobed opcode 0x1N with sel_pending clear sets dst_idx to N. It leaves src_idx, mode and sel_pending unchanged.
- R5: A strobed opcode 0xBN with sel_pending clear sets src_idx to N. It leaves dst_idx, mode and sel_pending unchanged.
- R6: A strobed opcode 0x1N with sel_pending set gives, in the following cycle, wr_en = 1 with wr_idx = N and wr_from = the old src_idx, and flag_we = 0. It also returns the block to the R1 state.
- R7: A strobed opcode 0xBN with sel_pending set gives, in the following cycle, wr_en = 1 with wr_idx = the old dst_idx and wr_from = N. It also gives flag_we = 1 with flag_ov = mv_data[7], flag_s = mv_data[15] and flag_z = (mv_data == 0). It returns the block to the R1 state.
- R8: Any other strobed opcode returns the block to the R1 state and gives no write.
- R9: A cycle with op_valid low changes none of mode, sel_pending, src_idx or dst_idx, and gives no write.
- R10: wr_en and flag_we last exactly one cycle per move. flag_we is never high without wr_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode strobe |
| op_byte | input | 8 | Decoded opcode byte |
| mv_data | input | 16 | Contents of the register named by the opcode's low nibble, valid with the strobe |
| mode | output | 2 | Variant mode {alt2, alt1} |
| sel_pending | output | 1 | Register-select prefix pending |
| src_idx | output | 4 | Source register pointer |
| dst_idx | output | 4 | Destination register pointer |
| wr_en | output | 1 | Register-file write command for a move |
| wr_idx | output | 4 | Register written by the move |
| wr_from | output | 4 | Register copied by the move |
| flag_we | output | 1 | Flag update strobe |
| flag_ov | output | 1 | Overflow flag value |
| flag_s | output | 1 | Sign flag value |
| flag_z | output | 1 | Zero flag value |

## Verification
All of this block's state appears directly on its outputs one edge after the strobe that changes it. A corrupted mode, pending bit or pointer is therefore visible at the ports in the very next cycle, and the bench compares every output against its own model on every clock. Some faults only show later, such as a pending bit that is not cleared after an alternate prefix. Those are exposed when a following 0x1N or 0xBN opcode either wrongly raises wr_en or wrongly moves a pointer.

// File: rtl/prefix_seq_pkg.sv
`timescale 1ns/1ps
package prefix_seq_pkg;

    typedef enum logic [2:0] {
        OPC_NONE,
        OPC_WITH,
        OPC_ALT,
        OPC_TO,
        OPC_FROM,
        OPC_OTHER
    } opc_e;

    // encoding: bits [2:1] are the mode {alt2, alt1}, bit 0 is select pending
    typedef enum logic [2:0] {
        PS_M0  = 3'b000,
        PS_M0S = 3'b001,
        PS_M1  = 3'b010,
        PS_M1S = 3'b011,
        PS_M2  = 3'b100,
        PS_M2S = 3'b101,
        PS_M3  = 3'b110,
        PS_M3S = 3'b111
    } ps_e;

    localparam logic [3:0] GRP_TO   = 4'h1;
    localparam logic [3:0] GRP_WITH = 4'h2;
    localparam logic [3:0] GRP_FROM = 4'hB;
    localparam logic [7:0] OP_ALT1  = 8'h3D;
    localparam logic [7:0] OP_ALT2  = 8'h3E;
    localparam logic [7:0] OP_ALT3  = 8'h3F;

endpackage

// File: rtl/psq_decode.sv
`timescale 1ns/1ps
module psq_decode
    import prefix_seq_pkg::*;
#(
    parameter int OP_W  = 8,
    parameter int IDX_W = 4
) (
    input  logic [OP_W-1:0]  op,
    input  logic             valid,
    output opc_e             cls,
    output logic [IDX_W-1:0] nib,
    output logic [1:0]       alt_set
);
    localparam int GRP_LSB = OP_W - 4;

    logic [3:0] grp;

    always_comb begin
        grp     = op[OP_W-1:GRP_LSB];
        nib     = op[IDX_W-1:0];
        alt_set = 2'b00;
        cls     = OPC_NONE;
        if (valid) begin
            if (grp == GRP_WITH) begin
                cls = OPC_WITH;
            end else if (grp == GRP_TO) begin
                cls = OPC_TO;
            end else if (grp == GRP_FROM) begin
                cls = OPC_FROM;
            end else if (op == OP_ALT1 || op == OP_ALT2 || op == OP_ALT3) begin
                cls     = OPC_ALT;
                alt_set = op[1:0];
            end else begin
                cls = OPC_OTHER;
            end
        end
    end
endmodule

// File: rtl/psq_mode_fsm.sv
`timescale 1ns/1ps
module psq_mode_fsm
    import prefix_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  opc_e       cls,
    input  logic [1:0] alt_set,
    output logic [1:0] mode,
    output logic       sel,
    output logic       move_to,
    output logic       move_from,
    output logic       clr
);
    ps_e        state, nxt;
    logic [1:0] cur_mode;
    logic       cur_sel;

    always_ff @(posedge clk) begin
        if (rst) state <= PS_M0;
        else     state <= nxt;
    end

    always_comb begin
        unique case (state)
            PS_M0:   begin cur_mode = 2'd0; cur_sel = 1'b0; end
            PS_M0S:  begin cur_mode = 2'd0; cur_sel = 1'b1; end
            PS_M1:   begin cur_mode = 2'd1; cur_sel = 1'b0; end
            PS_M1S:  begin cur_mode = 2'd1; cur_sel = 1'b1; end
            PS_M2:   begin cur_mode = 2'd2; cur_sel = 1'b0; end
            PS_M2S:  begin cur_mode = 2'd2; cur_sel = 1'b1; end
            PS_M3:   begin cur_mode = 2'd3; cur_sel = 1'b0; end
            PS_M3S:  begin cur_mode = 2'd3; cur_sel = 1'b1; end
            default: begin cur_mode = 2'd0; cur_sel = 1'b0; end
        endcase
    end

    always_comb begin
        nxt       = state;
        move_to   = 1'b0;
        move_from = 1'b0;
        clr       = 1'b0;
        unique case (cls)
            OPC_NONE: nxt = state;
            OPC_WITH: nxt = ps_e'({cur_mode, 1'b1});
            OPC_ALT:  nxt = ps_e'({cur_mode | alt_set, 1'b0});
            OPC_TO: begin
                if (cur_sel) begin
                    nxt     = PS_M0;
                    move_to = 1'b1;
                    clr     = 1'b1;
                end
            end
            OPC_FROM: begin
                if (cur_sel) begin
                    nxt       = PS_M0;
                    move_from = 1'b1;
                    clr       = 1'b1;
                end
            end
            OPC_OTHER: begin
                nxt = PS_M0;
                clr = 1'b1;
            end
            default: nxt = PS_M0;
        endcase
    end

    assign mode = cur_mode;
    assign sel  = cur_sel;

    // R3
    alt_or_chk: assert property (@(posedge clk) disable iff (rst)
        (cls == OPC_ALT) |=> (!sel && ((mode & $past(alt_set)) == $past(alt_set))
                              && ((mode & ~$past(alt_set)) == ($past(mode) & ~$past(alt_set)))));

    // R8
    other_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cls == OPC_OTHER) |=> (mode == 2'd0 && !sel));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cls == OPC_NONE) |=> ($stable(mode) && $stable(sel)));

    // R2
    with_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (cls == OPC_WITH) |=> (sel && $stable(mode)));
endmodule

// File: rtl/psq_ptr_file.sv
`timescale 1ns/1ps
module psq_ptr_file
    import prefix_seq_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  opc_e             cls,
    input  logic             sel,
    input  logic             clr,
    input  logic [IDX_W-1:0] nib,
    output logic [IDX_W-1:0] src,
    output logic [IDX_W-1:0] dst
);
    localparam int NPTR    = 2;
    localparam int SRC_SEL = 0;

    logic [IDX_W-1:0] ptr_q [NPTR];

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        localparam opc_e OWN_CLS = (g == SRC_SEL) ? OPC_FROM : OPC_TO;
        logic load;
        assign load = (cls == OPC_WITH) || ((cls == OWN_CLS) && !sel);
        always_ff @(posedge clk) begin
            if (rst || clr)  ptr_q[g] <= '0;
            else if (load)   ptr_q[g] <= nib;
        end
    end

    assign src = ptr_q[SRC_SEL];
    assign dst = ptr_q[1 - SRC_SEL];

    // R4
    to_dst_chk: assert property (@(posedge clk) disable iff (rst)
        (cls == OPC_TO && !sel) |=> (dst == $past(nib) && $stable(src)));

    // R5
    from_src_chk: assert property (@(posedge clk) disable iff (rst)
        (cls == OPC_FROM && !sel) |=> (src == $past(nib) && $stable(dst)));

    // R2
    with_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (cls == OPC_WITH) |=> (src == $past(nib) && dst == $past(nib)));
endmodule

// File: rtl/prefix_seq.sv
`timescale 1ns/1ps
module prefix_seq
    import prefix_seq_pkg::*;
#(
    parameter int OP_W   = 8,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_byte,
    input  logic [DATA_W-1:0] mv_data,
    output logic [1:0]        mode,
    output logic              sel_pending,
    output logic [IDX_W-1:0]  src_idx,
    output logic [IDX_W-1:0]  dst_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [IDX_W-1:0]  wr_from,
    output logic              flag_we,
    output logic              flag_ov,
    output logic              flag_s,
    output logic              flag_z
);
    localparam int OV_BIT = 7;
    localparam int S_BIT  = DATA_W - 1;

    opc_e             cls;
    logic [IDX_W-1:0] nib;
    logic [1:0]       alt_set;
    logic             move_to, move_from, clr;

    psq_decode #(.OP_W(OP_W), .IDX_W(IDX_W)) u_dec (
        .op(op_byte), .valid(op_valid), .cls(cls), .nib(nib), .alt_set(alt_set)
    );

    psq_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .cls(cls), .alt_set(alt_set),
        .mode(mode), .sel(sel_pending),
        .move_to(move_to), .move_from(move_from), .clr(clr)
    );

    psq_ptr_file #(.IDX_W(IDX_W)) u_ptr (
        .clk(clk), .rst(rst), .cls(cls), .sel(sel_pending), .clr(clr),
        .nib(nib), .src(src_idx), .dst(dst_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_from <= '0;
            flag_we <= 1'b0;
            flag_ov <= 1'b0;
            flag_s  <= 1'b0;
            flag_z  <= 1'b0;
        end else begin
            wr_en   <= move_to || move_from;
            flag_we <= move_from;
            if (move_to) begin
                wr_idx  <= nib;
                wr_from <= src_idx;
            end else if (move_from) begin
                wr_idx  <= dst_idx;
                wr_from <= nib;
                flag_ov <= mv_data[OV_BIT];
                flag_s  <= mv_data[S_BIT];
                flag_z  <= (mv_data == '0);
            end
        end
    end

    // R10
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R10
    flag_needs_wr_chk: assert property (@(posedge clk) disable iff (rst)
        flag_we |-> wr_en);

    // R6
    move_resets_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (mode == 2'd0 && !sel_pending && src_idx == '0 && dst_idx == '0));

    // R7
    from_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_byte[OP_W-1:OP_W-4] == GRP_FROM && sel_pending)
            |=> (flag_we && flag_z == ($past(mv_data) == '0)));
endmodule

// File: tb/prefix_seq_test.sv
`timescale 1ns/1ps
module prefix_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [7:0]  op_byte = 8'h00;
    logic [15:0] mv_data = 16'h0000;
    logic [1:0]  mode;
    logic        sel_pending, wr_en, flag_we, flag_ov, flag_s, flag_z;
    logic [3:0]  src_idx, dst_idx, wr_idx, wr_from;

    int total = 0;
    int bad = 0;

    int e_mode = 0, e_sel = 0, e_src = 0, e_dst = 0;
    int e_we = 0, e_widx = 0, e_wfrom = 0;
    int e_fwe = 0, e_ov = 0, e_s = 0, e_z = 0;
    int lfsr = 32'h1ACE5;

    always #2.5 clk = ~clk;

    prefix_seq uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_byte(op_byte), .mv_data(mv_data),
        .mode(mode), .sel_pending(sel_pending), .src_idx(src_idx), .dst_idx(dst_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_from(wr_from),
        .flag_we(flag_we), .flag_ov(flag_ov), .flag_s(flag_s), .flag_z(flag_z)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "mode", int'(mode), e_mode);
        chk(tag, "sel_pending", int'(sel_pending), e_sel);
        chk(tag, "src_idx", int'(src_idx), e_src);
        chk(tag, "dst_idx", int'(dst_idx), e_dst);
        chk(tag, "wr_en", int'(wr_en), e_we);
        chk(tag, "flag_we", int'(flag_we), e_fwe);
        if (e_we != 0) begin
            chk(tag, "wr_idx", int'(wr_idx), e_widx);
            chk(tag, "wr_from", int'(wr_from), e_wfrom);
        end
        if (e_fwe != 0) begin
            chk(tag, "flag_ov", int'(flag_ov), e_ov);
            chk(tag, "flag_s", int'(flag_s), e_s);
            chk(tag, "flag_z", int'(flag_z), e_z);
        end
    endtask

    task automatic model_clear();
        e_mode = 0; e_sel = 0; e_src = 0; e_dst = 0;
    endtask

    // called at a negative edge; applies one cycle of stimulus and checks after the next posedge
    task automatic step(input bit v, input int op, input int data, input string tag);
        int n;
        int hi;
        op_valid = v;
        op_byte  = op[7:0];
        mv_data  = data[15:0];
        n  = op & 15;
        hi = (op >> 4) & 15;
        e_we = 0; e_fwe = 0;
        if (v) begin
            if (hi == 2) begin
                e_src = n; e_dst = n; e_sel = 1;
            end else if (op == 'h3D || op == 'h3E || op == 'h3F) begin
                e_mode = e_mode | (op & 3); e_sel = 0;
            end else if (hi == 1) begin
                if (e_sel != 0) begin
                    e_we = 1; e_widx = n; e_wfrom = e_src;
                    model_clear();
                end else e_dst = n;
            end else if (hi == 'hB) begin
                if (e_sel != 0) begin
                    e_we = 1; e_fwe = 1; e_widx = e_dst; e_wfrom = n;
                    e_ov = (data >> 7) & 1;
                    e_s  = (data >> 15) & 1;
                    e_z  = ((data & 'hFFFF) == 0) ? 1 : 0;
                    model_clear();
                end else e_src = n;
            end else begin
                model_clear();
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; op_valid = 1'b0;
        model_clear(); e_we = 0; e_fwe = 0;
        @(negedge clk);
        @(negedge clk);
        compare("R1");
        rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        step(1, 'h25, 0, "R2");          // with r5
        step(1, 'h13, 0, "R6");          // move r3 <- r5
        step(0, 'h13, 0, "R9");          // no strobe, must not act
        step(1, 'h17, 0, "R4");          // dst = 7
        step(0, 'h2A, 0, "R9");
        step(1, 'hB9, 0, "R5");          // src = 9
        step(1, 'h3D, 0, "R3");          // mode 1
        step(1, 'h3E, 0, "R3");          // mode 3
        step(1, 'h22, 0, "R2");          // with r2 keeps mode 3
        step(1, 'hB4, 'h8080, "R7");     // ov=1 s=1 z=0
        step(1, 'h2C, 0, "R2");
        step(1, 'hB1, 'h0000, "R7");     // z=1
        step(1, 'h2C, 0, "R2");
        step(1, 'hB6, 'h7F7F, "R7");     // ov=0 s=0 z=0
        step(1, 'h3F, 0, "R3");          // mode 3
        step(1, 'h1E, 0, "R4");
        step(1, 'h50, 0, "R8");          // ordinary op clears
        step(1, 'h28, 0, "R2");
        step(1, 'h3D, 0, "R3");          // clears pending
        step(1, 'h14, 0, "R3");          // acts as pointer, no write
        step(1, 'hB2, 0, "R5");
        step(1, 'h00, 0, "R8");
        step(1, 'h27, 0, "R2");
        step(1, 'h11, 0, "R10");         // move then idle: single pulse
        step(0, 'h00, 0, "R10");
        step(1, 'h2F, 0, "R2");
        do_reset();

        for (int i = 0; i < 600; i++) begin
            int op;
            int d;
            lfsr = (lfsr << 1) ^ (((lfsr >> 31) & 1) != 0 ? 'h04C11DB7 : 0);
            d = lfsr & 'hFFFF;
            unique case ((lfsr >> 17) & 7)
                0, 1: op = 'h20 | (lfsr & 15);
                2:    op = 'h10 | ((lfsr >> 4) & 15);
                3:    op = 'hB0 | ((lfsr >> 8) & 15);
                4:    op = 'h3D + ((lfsr >> 12) % 3);
                5:    op = (lfsr >> 20) & 'hFF;
                default: op = 'hB0 | ((lfsr >> 3) & 15);
            endcase
            if (((lfsr >> 25) & 7) == 0) d = 0;
            step(((lfsr >> 28) & 7) != 0, op, d, "R8");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule